// File: doc/BRIEF.md
# Packed dual-product multiplier pipeline

This block multiplies two unsigned 8-bit multiplicands by one shared 8-bit multiplier and returns both products packed side by side in a single 32-bit word. It is a three-stage pipeline: an operand register, a multiply register and a result register. Each stage carries its own valid flag.

Both edges of the block use a valid/ready handshake. An item moves across a channel on a clock edge when valid and ready were both high in the cycle before that edge. Upstream sees `in_ready` and downstream drives `out_ready`. Backpressure travels through a purely combinational stall chain. A stage stalls only if the stage after it stalls and it holds an item of its own. Under backpressure, empty slots keep filling until all three stages are occupied.

Consumers must wait for `out_valid` and must not count cycles. Items leave in the order they were accepted. No item is lost and none is repeated.

Top module: `pkmul_pipe`

## Requirements
- R1: A result word holds `a0*b` in bits 15:0 and `a1*b` in bits 31:16, where all operands are unsigned 8-bit values.
- R2: While reset is high and on the cycle after it, `out_valid` is 0 and `in_ready` is 1. The reset is synchronous and active high.
- R3: Every item accepted on the input (`in_valid` and `in_ready` high before an edge) is delivered exactly once on the output (`out_valid` and `out_ready` high before an edge), in acceptance order.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_prod` stays unchanged into the next cycle.
- R5: `in_ready` is 0 only when all three stages hold an item and `out_ready` is 0. In particular, `out_ready` high forces `in_ready` high.
- R6: With `out_ready` held low, the block accepts exactly three items, whatever gaps separate them, and then holds `in_ready` low.
- R7: With `out_ready` high and the pipeline empty, an item accepted at clock edge E makes `out_valid` high after edge E+2, that is, at the third edge counting E.
- R8: Operand values presented while `in_valid` is 0 are never accepted and never produce an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream has an operand set |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_a0 | input | 8 | First multiplicand |
| in_a1 | input | 8 | Second multiplicand |
| in_b | input | 8 | Shared multiplier |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Downstream accepts the result |
| out_prod | output | 32 | Packed products {a1*b, a0*b} |

## Verification
The hardest state to reach from the ports is a pipeline that holds bubbles while the output is blocked. In that state the stages ahead of the bubbles must fill in while the head item stays frozen. The stimulus holds `out_ready` low and offers items with idle cycles between them. It then confirms that exactly three items go in, that the head result stays fixed, and that a fourth offer is refused. A pseudo-random `out_ready` pattern, run against a steady stream, then exercises stall and release in every stage pairing while a scoreboard tracks order.

// File: rtl/pkmul_pipe.sv
module pkmul_pipe #(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int PW = AW + BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_a0,
  input  logic [AW-1:0]   in_a1,
  input  logic [BW-1:0]   in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*PW-1:0] out_prod
);

  logic          v0, v1, v2;
  logic [AW-1:0] a0_q, a1_q;
  logic [BW-1:0] b_q;
  logic [PW-1:0] p0_q, p1_q;
  logic [2*PW-1:0] res_q;
  logic          st0, st1, st2;

  assign st2 = v2 & ~out_ready;
  assign st1 = v1 & st2;
  assign st0 = v0 & st1;
  assign in_ready  = ~st0;
  assign out_valid = v2;
  assign out_prod  = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0; a0_q <= '0; a1_q <= '0; b_q <= '0;
    end else if (!st0) begin
      v0 <= in_valid;
      if (in_valid) begin
        a0_q <= in_a0; a1_q <= in_a1; b_q <= in_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; p0_q <= '0; p1_q <= '0;
    end else if (!st1) begin
      v1 <= v0;
      if (v0) begin
        p0_q <= PW'(a0_q) * PW'(b_q);
        p1_q <= PW'(a1_q) * PW'(b_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; res_q <= '0;
    end else if (!st2) begin
      v2 <= v1;
      if (v1) res_q <= {p1_q, p0_q};
    end
  end

  // R2: reset leaves an empty, ready pipeline
  a_r2_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

  // R4: blocked result stays put
  a_r4_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R5: downstream ready never blocks upstream
  a_r5_ready_passes: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R5: a refused input means every stage is full
  a_r5_full_when_refused: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (v0 && v1 && v2 && !out_ready));

  // R6: a bubble in the middle is filled while the output is blocked
  a_r6_bubble_fills: assert property (@(posedge clk) disable iff (rst)
    (v2 && !out_ready && !v1 && v0) |=> (v1 && !v0 == !$past(in_valid)));

  // R6: the head of a blocked pipeline does not move
  a_r6_head_frozen: assert property (@(posedge clk) disable iff (rst)
    (v2 && !out_ready) |=> v2);

endmodule

// File: tb/pkmul_pipe_tb.sv
module pkmul_pipe_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_a0 = '0, in_a1 = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_prod;

  int errors = 0, checks = 0;
  int wr = 0, rd = 0;
  logic [31:0] sb [0:127];
  logic [31:0] exp_cur = '0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_prod = '0;
  logic        rand_bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 0;

  always #2 clk = ~clk;

  pkmul_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a0(in_a0), .in_a1(in_a1), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod));

  localparam logic [55:0] VEC [0:7] = '{
    {8'd0,   8'd0,   8'd0,   32'h0000_0000},
    {8'd255, 8'd255, 8'd255, 32'hFE01_FE01},
    {8'd1,   8'd2,   8'd3,   32'h0006_0003},
    {8'd16,  8'd1,   8'd16,  32'h0010_0100},
    {8'd200, 8'd0,   8'd100, 32'h0000_4E20},
    {8'd0,   8'd255, 8'd2,   32'h01FE_0000},
    {8'd12,  8'd34,  8'd56,  32'h0770_02A0},
    {8'd128, 8'd127, 8'd255, 32'h7E81_7F80}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [7:0] x0, input logic [7:0] x1, input logic [7:0] y);
    return {16'(x1) * 16'(y), 16'(x0) * 16'(y)};
  endfunction

  // monitor: R1/R3 scoreboard, R4 hold
  always @(negedge clk) if (!rst && !done) begin
    if (prev_hold)
      check(out_valid && out_prod == prev_prod, "R4 hold", out_prod, prev_prod);
    prev_hold = out_valid && !out_ready;
    prev_prod = out_prod;
    if (in_valid && in_ready) begin sb[wr] = exp_cur; wr++; end
    if (out_valid && out_ready) begin
      check(rd < wr && out_prod == sb[rd], "R1/R3 result order", out_prod, sb[rd]);
      rd++;
    end
  end

  always @(posedge clk) if (rand_bp) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = lfsr[0] | lfsr[3];
  end

  task automatic wait_accept();
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] x0, input logic [7:0] x1, input logic [7:0] y, input logic [31:0] e);
    in_a0 = x0; in_a1 = x1; in_b = y; exp_cur = e; in_valid = 1'b1;
    wait_accept();
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    // R2 reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R2 in reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R2 after reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;

    // R1 table walk, unblocked
    for (int i = 0; i < 8; i++)
      send(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:0]);
    idle(5);
    check(rd == 8, "R1 table drained", rd, 8);

    // R7 latency
    send(8'd3, 8'd5, 8'd7, 32'h0023_0015);
    @(negedge clk); check(!out_valid, "R7 edge E", out_valid, 0);
    @(negedge clk); check(!out_valid, "R7 edge E+1", out_valid, 0);
    @(negedge clk); check(out_valid && out_prod == 32'h0023_0015, "R7 edge E+2", out_prod, 32'h0023_0015);
    idle(3);

    // R6 fill back-to-back while blocked
    out_ready = 1'b0;
    send(8'd10, 8'd20, 8'd3, model(8'd10, 8'd20, 8'd3));
    send(8'd11, 8'd21, 8'd4, model(8'd11, 8'd21, 8'd4));
    send(8'd12, 8'd22, 8'd5, model(8'd12, 8'd22, 8'd5));
    in_a0 = 8'd13; in_a1 = 8'd23; in_b = 8'd6; exp_cur = model(8'd13, 8'd23, 8'd6); in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!in_ready, "R6 fourth refused", in_ready, 0);
      check(out_valid && out_prod == model(8'd10, 8'd20, 8'd3), "R6 head frozen", out_prod, model(8'd10, 8'd20, 8'd3));
    end
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk); check(in_ready, "R5 ready follows out_ready", in_ready, 1);
    @(posedge clk); #1 in_valid = 1'b0;
    idle(5);

    // R6 fill with gaps
    out_ready = 1'b0;
    send(8'd40, 8'd41, 8'd9, model(8'd40, 8'd41, 8'd9));
    idle(2);
    send(8'd50, 8'd51, 8'd8, model(8'd50, 8'd51, 8'd8));
    idle(1);
    send(8'd60, 8'd61, 8'd7, model(8'd60, 8'd61, 8'd7));
    idle(1);
    @(negedge clk);
    check(!in_ready, "R5/R6 full after gaps", in_ready, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    idle(6);

    // R8 data without valid ignored
    for (int k = 0; k < 6; k++) begin
      in_a0 = 8'(k * 37); in_a1 = 8'(k * 11); in_b = 8'hFF;
      @(negedge clk);
      check(!out_valid, "R8 no output without valid", out_valid, 0);
      @(posedge clk); #1;
    end

    // R3 stream under random backpressure
    rand_bp = 1'b1;
    for (int k = 0; k < 40; k++) begin
      send(8'(k * 7 + 1), 8'(255 - k * 5), 8'(k * 13 + 2),
           model(8'(k * 7 + 1), 8'(255 - k * 5), 8'(k * 13 + 2)));
      if (k % 5 == 0) idle(1);
    end
    rand_bp = 1'b0;
    @(posedge clk); #1 out_ready = 1'b1;
    idle(8);
    check(rd == wr && wr == 56, "R3 all delivered once", rd, wr);
    summary();
  end
endmodule